// File: doc/BRIEF.md
# SDRAM Data-Path Burst Sequencer

This block handles the data side of an SDRAM controller once a separate command scheduler has issued a READ or WRITE. It takes a start strobe together with two "more words pending" flags. It then moves one SDRAM data beat per clock between the memory pins and a wider host word. The SDRAM bus is narrower than the host word by a factor of 1, 2, 4 or 8. Each host word is therefore split into, or assembled from, several consecutive beats, and the most significant part always travels first.

On a read, the sequencer waits out the CAS latency (2 or 3 clocks, fixed by a parameter). It captures each beat on the rising clock edge and shifts the beats into a host-width word. When a word is complete it presents the word with a one-cycle valid pulse. On a write, it slices the host word and its byte enables into beats. It drives the data, the active-high byte mask and the tri-state control, and pulses a "next word" strobe so the source can advance. After the last write word it holds through a write-recovery interval. Every burst ends with a one-cycle completion pulse. A parameter chooses whether the write-side pin registers switch on the falling edge (the default) or on the rising edge.

Top module: `sdr_burst_datapath`

## Requirements
- R1: While `rst` is high and after it falls until a transfer starts, `mem_dq_t` is 1, `mem_dq_o` and `mem_dqm` are 0, and `host_rvalid`, `host_wnext` and `xfer_done` are 0.
- R2: A read starts when `data_en` and `pend_rd` are both sampled high while the sequencer is idle. The first beat is sampled from `mem_dq_i` on the CAS_LAT-th rising edge after that edge. No `host_rvalid` occurs during the wait.
- R3: The RATIO = HOST_W/MEM_W beats of one host word arrive most significant first. Beat b fills `host_rdata[HOST_W-1-MEM_W*b -: MEM_W]`. `host_rdata` updates and `host_rvalid` is high for exactly the one cycle after the edge that captured the word's last beat.
- R4: `pend_rd` is sampled on each word's last beat. If it is high, the next word's first beat is captured on the next edge with no gap. If it is low, `xfer_done` is high for one cycle in the same cycle as the final `host_rvalid`, and the sequencer returns to idle.
- R5: A write starts when `data_en` and `pend_wr` are sampled high, with `pend_rd` low, while the sequencer is idle. Beat b of `host_wdata` (most significant first, same slicing as R3) is driven in the b-th cycle after the start. With the falling-edge option the pin value appears at the falling edge inside that cycle. `host_wnext` is high during the cycle of each word's last beat.
- R6: During write beat b, `mem_dqm[MB-1-i]` (MB = MEM_W/8) is the inverse of the enable of host byte MB*b+i. Host byte k (k = 0 most significant) has its enable at `host_be[NB-1-k]`. A mask bit of 1 blocks that byte.
- R7: `mem_dq_t` is 0 only for driven write beats and 1 at all other times. `mem_dq_o` and `mem_dqm` are 0 whenever `mem_dq_t` is 1.
- R8: `pend_wr` is sampled on each write word's last beat. If it is low, the sequencer spends TWR_CYC cycles in write recovery with pins released, and then raises `xfer_done` for one cycle.
- R9: `data_en` has no effect when neither pending flag is set or when the sequencer is not idle. When both flags are set, a read is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_en | input | 1 | Start of a data transfer from the command scheduler |
| pend_rd | input | 1 | Read words remain to be transferred |
| pend_wr | input | 1 | Write words remain to be transferred |
| host_wdata | input | HOST_W | Host write word, most significant byte is byte 0 |
| host_be | input | HOST_W/8 | Host byte enables, byte k at bit NB-1-k |
| mem_dq_i | input | MEM_W | Read data from the SDRAM pins |
| host_rdata | output | HOST_W | Assembled host read word |
| host_rvalid | output | 1 | One-cycle pulse: host_rdata holds a new word |
| host_wnext | output | 1 | Last beat of the current write word is being driven |
| xfer_done | output | 1 | One-cycle pulse at the end of a burst |
| mem_dq_o | output | MEM_W | Write data to the SDRAM pins |
| mem_dqm | output | MEM_W/8 | Byte mask to the SDRAM, 1 = blocked |
| mem_dq_t | output | 1 | Pin tri-state control, 1 = released |

## Verification
Wrong internal state shows up at the pins within a beat or two. A miscounted CAS wait shifts every read word by one beat, so `host_rdata` holds a rotated value at its first `host_rvalid`. A beat counter that wraps wrongly moves `host_wnext` and the mask slices out of place in the very next write cycle. A state that misses the recovery interval raises `xfer_done` early, and a late exit from the write state leaves `mem_dq_t` low in a cycle where it must be released. The bench sweeps single-byte enables across every lane and runs multi-word bursts in both directions, so a fault in slicing, packing or sequencing causes a mismatch inside the burst where it occurs.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;
  typedef enum logic [2:0] {
    DP_IDLE,
    DP_WAIT_CL,
    DP_READ,
    DP_WRITE,
    DP_WAIT_WR,
    DP_DONE
  } dp_state_e;
endpackage

// File: rtl/sdr_dp_fsm.sv
module sdr_dp_fsm
  import sdr_dp_pkg::*;
#(
  parameter int RATIO   = 4,
  parameter int CAS_LAT = 2,
  parameter int TWR_CYC = 2,
  localparam int BW     = (RATIO > 1) ? $clog2(RATIO) : 1,
  localparam int MAXW   = (CAS_LAT > TWR_CYC) ? CAS_LAT : TWR_CYC,
  localparam int CW     = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_en,
  input  logic          pend_rd,
  input  logic          pend_wr,
  output dp_state_e     st,
  output logic [BW-1:0] beat,
  output logic          last_beat
);
  dp_state_e     nxt;
  logic [CW-1:0] wcnt;

  assign last_beat = (beat == BW'(RATIO - 1));

  always_comb begin
    nxt = st;
    unique case (st)
      DP_IDLE: begin
        if (data_en && pend_rd)      nxt = DP_WAIT_CL;
        else if (data_en && pend_wr) nxt = DP_WRITE;
      end
      DP_WAIT_CL: if (wcnt == CW'(CAS_LAT - 2)) nxt = DP_READ;
      DP_READ:    if (last_beat && !pend_rd) nxt = DP_DONE;
      DP_WRITE:   if (last_beat && !pend_wr) nxt = DP_WAIT_WR;
      DP_WAIT_WR: if (wcnt == CW'(TWR_CYC - 1)) nxt = DP_DONE;
      DP_DONE:    nxt = DP_IDLE;
      default:    nxt = DP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= DP_IDLE;
      wcnt <= '0;
      beat <= '0;
    end else begin
      st <= nxt;
      if (st != nxt)
        wcnt <= '0;
      else if (st == DP_WAIT_CL || st == DP_WAIT_WR)
        wcnt <= wcnt + 1'b1;
      if (st == DP_READ || st == DP_WRITE)
        beat <= last_beat ? '0 : beat + 1'b1;
      else
        beat <= '0;
    end
  end
endmodule

// File: rtl/sdr_dp_rdpack.sv
module sdr_dp_rdpack #(
  parameter int HOST_W = 64,
  parameter int MEM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              word_end,
  input  logic [MEM_W-1:0]  dq_i,
  output logic [HOST_W-1:0] rdata,
  output logic              rvalid
);
  logic [HOST_W-1:0] acc;

  // Earlier beats move toward the MSB; the newest beat lands at the bottom.
  function automatic logic [HOST_W-1:0] shift_in(logic [HOST_W-1:0] a,
                                                 logic [MEM_W-1:0]  d);
    logic [HOST_W-1:0] t;
    t = a << MEM_W;
    t[MEM_W-1:0] = d;
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture && word_end;
      if (capture) begin
        acc <= shift_in(acc, dq_i);
        if (word_end) rdata <= shift_in(acc, dq_i);
      end
    end
  end
endmodule

// File: rtl/sdr_dp_wrdrive.sv
module sdr_dp_wrdrive #(
  parameter int HOST_W      = 64,
  parameter int MEM_W       = 16,
  parameter bit POSEDGE_OUT = 1'b0,
  localparam int RATIO      = HOST_W / MEM_W,
  localparam int NB         = HOST_W / 8,
  localparam int MB         = MEM_W / 8,
  localparam int BW         = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive,
  input  logic [BW-1:0]     beat,
  input  logic [HOST_W-1:0] wdata,
  input  logic [NB-1:0]     be,
  output logic [MEM_W-1:0]  dq_o,
  output logic [MB-1:0]     dqm,
  output logic              dq_t
);
  function automatic logic [MEM_W-1:0] data_beat(logic [HOST_W-1:0] w,
                                                 logic [BW-1:0]     b);
    logic [HOST_W-1:0] s;
    s = w >> (HOST_W - MEM_W * (int'(b) + 1));
    return s[MEM_W-1:0];
  endfunction

  function automatic logic [MB-1:0] mask_beat(logic [NB-1:0] e,
                                              logic [BW-1:0] b);
    logic [NB-1:0] s;
    s = e >> (NB - MB * (int'(b) + 1));
    return ~s[MB-1:0];
  endfunction

  logic [MEM_W-1:0] nx_o;
  logic [MB-1:0]    nx_m;
  logic             nx_t;

  always_comb begin
    nx_o = drive ? data_beat(wdata, beat) : '0;
    nx_m = drive ? mask_beat(be, beat) : '0;
    nx_t = !drive;
  end

  generate
    if (POSEDGE_OUT) begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) begin
          dq_o <= '0; dqm <= '0; dq_t <= 1'b1;
        end else begin
          dq_o <= nx_o; dqm <= nx_m; dq_t <= nx_t;
        end
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) begin
          dq_o <= '0; dqm <= '0; dq_t <= 1'b1;
        end else begin
          dq_o <= nx_o; dqm <= nx_m; dq_t <= nx_t;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sdr_burst_datapath.sv
module sdr_burst_datapath
  import sdr_dp_pkg::*;
#(
  parameter int HOST_W      = 64,
  parameter int MEM_W       = 16,
  parameter int CAS_LAT     = 2,
  parameter int TWR_CYC     = 2,
  parameter bit POSEDGE_OUT = 1'b0,
  localparam int RATIO      = HOST_W / MEM_W,
  localparam int NB         = HOST_W / 8,
  localparam int MB         = MEM_W / 8,
  localparam int BW         = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_en,
  input  logic              pend_rd,
  input  logic              pend_wr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic [NB-1:0]     host_be,
  input  logic [MEM_W-1:0]  mem_dq_i,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              host_wnext,
  output logic              xfer_done,
  output logic [MEM_W-1:0]  mem_dq_o,
  output logic [MB-1:0]     mem_dqm,
  output logic              mem_dq_t
);
  dp_state_e     st;
  logic [BW-1:0] beat;
  logic          last_beat;

  // Named state events, used by the bound checker.
  logic in_idle, in_wcl, in_read, in_write, in_twr, in_done;
  assign in_idle  = (st == DP_IDLE);
  assign in_wcl   = (st == DP_WAIT_CL);
  assign in_read  = (st == DP_READ);
  assign in_write = (st == DP_WRITE);
  assign in_twr   = (st == DP_WAIT_WR);
  assign in_done  = (st == DP_DONE);

  assign xfer_done  = in_done;
  assign host_wnext = in_write && last_beat;

  sdr_dp_fsm #(.RATIO(RATIO), .CAS_LAT(CAS_LAT), .TWR_CYC(TWR_CYC)) u_fsm (
    .clk(clk), .rst(rst), .data_en(data_en), .pend_rd(pend_rd),
    .pend_wr(pend_wr), .st(st), .beat(beat), .last_beat(last_beat)
  );

  sdr_dp_rdpack #(.HOST_W(HOST_W), .MEM_W(MEM_W)) u_rd (
    .clk(clk), .rst(rst), .capture(in_read), .word_end(last_beat),
    .dq_i(mem_dq_i), .rdata(host_rdata), .rvalid(host_rvalid)
  );

  sdr_dp_wrdrive #(.HOST_W(HOST_W), .MEM_W(MEM_W), .POSEDGE_OUT(POSEDGE_OUT)) u_wr (
    .clk(clk), .rst(rst), .drive(in_write), .beat(beat), .wdata(host_wdata),
    .be(host_be), .dq_o(mem_dq_o), .dqm(mem_dqm), .dq_t(mem_dq_t)
  );
endmodule

// File: rtl/sdr_burst_datapath_chk.sv
module sdr_burst_datapath_chk (
  input logic clk,
  input logic rst,
  input logic in_idle,
  input logic in_wcl,
  input logic in_read,
  input logic in_write,
  input logic in_twr,
  input logic in_done,
  input logic last_beat,
  input logic host_rvalid,
  input logic host_wnext,
  input logic xfer_done,
  input logic mem_dq_t
);
  p_read_after_cl_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_read) |-> $past(in_wcl));

  p_rvalid_source_r3: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(in_read && last_beat));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  p_read_done_data_r4: assert property (@(posedge clk) disable iff (rst)
    (in_done && $past(in_read)) |-> host_rvalid);

  p_wnext_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    host_wnext |-> in_write);

  p_hiz_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (in_idle && $past(in_idle)) |-> mem_dq_t);

  p_enter_twr_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(in_twr) |-> $past(in_write && last_beat));

  p_no_skip_twr_r8: assert property (@(posedge clk) disable iff (rst)
    in_done |-> !$past(in_write));
endmodule

bind sdr_burst_datapath sdr_burst_datapath_chk u_chk (
  .clk(clk), .rst(rst), .in_idle(in_idle), .in_wcl(in_wcl),
  .in_read(in_read), .in_write(in_write), .in_twr(in_twr),
  .in_done(in_done), .last_beat(last_beat), .host_rvalid(host_rvalid),
  .host_wnext(host_wnext), .xfer_done(xfer_done), .mem_dq_t(mem_dq_t)
);

// File: tb/tb_sdr_burst_datapath.sv
module tb_sdr_burst_datapath;
  localparam int HW  = 64;
  localparam int MW  = 16;
  localparam int R   = HW / MW;
  localparam int NB  = HW / 8;
  localparam int MB  = MW / 8;
  localparam int CL  = 2;
  localparam int TWR = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          data_en, pend_rd, pend_wr;
  logic [HW-1:0] host_wdata;
  logic [NB-1:0] host_be;
  logic [MW-1:0] mem_dq_i;
  logic [HW-1:0] host_rdata;
  logic          host_rvalid, host_wnext, xfer_done;
  logic [MW-1:0] mem_dq_o;
  logic [MB-1:0] mem_dqm;
  logic          mem_dq_t;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdr_burst_datapath #(.HOST_W(HW), .MEM_W(MW), .CAS_LAT(CL), .TWR_CYC(TWR),
                       .POSEDGE_OUT(1'b0)) dut (
    .clk(clk), .rst(rst), .data_en(data_en), .pend_rd(pend_rd),
    .pend_wr(pend_wr), .host_wdata(host_wdata), .host_be(host_be),
    .mem_dq_i(mem_dq_i), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .host_wnext(host_wnext), .xfer_done(xfer_done), .mem_dq_o(mem_dq_o),
    .mem_dqm(mem_dqm), .mem_dq_t(mem_dq_t)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] xbeat(logic [63:0] w, int b);
    return (w >> (HW - MW * (b + 1))) & ((64'd1 << MW) - 1);
  endfunction

  function automatic logic [63:0] xmask(logic [NB-1:0] e, int b);
    logic [63:0] s;
    s = 64'(e) >> (NB - MB * (b + 1));
    return ~s & ((64'd1 << MB) - 1);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic read_burst(int n, logic [63:0] w0, logic [63:0] w1, logic [63:0] w2);
    logic [63:0] words [3];
    logic        expv;
    logic [63:0] prev;
    words[0] = w0; words[1] = w1; words[2] = w2;
    data_en = 1'b1; pend_rd = 1'b1;
    step();
    data_en = 1'b0;
    for (int i = 0; i < CL - 1; i++) begin
      #8;
      chk("R2 no rvalid in CAS wait", host_rvalid, 0);
      chk("R7 released in CAS wait", mem_dq_t, 1);
      step();
    end
    expv = 1'b0; prev = '0;
    for (int w = 0; w < n; w++) begin
      for (int b = 0; b < R; b++) begin
        mem_dq_i = MW'(xbeat(words[w], b));
        pend_rd  = (w < n - 1);
        #8;
        chk("R3 rvalid timing", host_rvalid, expv);
        if (expv) chk("R3 packed word", host_rdata, prev);
        chk("R4 no early done", xfer_done, 0);
        chk("R7 released on read", mem_dq_t, 1);
        step();
        expv = (b == R - 1);
        prev = words[w];
      end
    end
    #8;
    chk("R3 final rvalid", host_rvalid, 1);
    chk("R3 final word", host_rdata, words[n-1]);
    chk("R4 done with last word", xfer_done, 1);
    step();
    #8;
    chk("R4 done single cycle", xfer_done, 0);
    chk("R3 rvalid single cycle", host_rvalid, 0);
    step();
    pend_rd = 1'b0;
  endtask

  task automatic write_burst(int n, logic [63:0] w0, logic [63:0] w1, logic [63:0] w2,
                             logic [NB-1:0] e0, logic [NB-1:0] e1, logic [NB-1:0] e2);
    logic [63:0]   words [3];
    logic [NB-1:0] bes [3];
    words[0] = w0; words[1] = w1; words[2] = w2;
    bes[0] = e0; bes[1] = e1; bes[2] = e2;
    data_en = 1'b1; pend_wr = 1'b1; host_wdata = w0; host_be = e0;
    step();
    data_en = 1'b0;
    for (int w = 0; w < n; w++) begin
      for (int b = 0; b < R; b++) begin
        host_wdata = words[w]; host_be = bes[w]; pend_wr = (w < n - 1);
        #8;
        chk("R5 write beat data", mem_dq_o, xbeat(words[w], b));
        chk("R6 write beat mask", mem_dqm, xmask(bes[w], b));
        chk("R7 driven on write beat", mem_dq_t, 0);
        chk("R5 wnext on last beat", host_wnext, (b == R - 1));
        step();
      end
    end
    for (int t = 0; t < TWR; t++) begin
      #8;
      chk("R7 released in recovery", mem_dq_t, 1);
      chk("R7 data zero in recovery", mem_dq_o, 0);
      chk("R8 no done in recovery", xfer_done, 0);
      step();
    end
    #8;
    chk("R8 done after recovery", xfer_done, 1);
    step();
    #8;
    chk("R8 done single cycle", xfer_done, 0);
    step();
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; data_en = 1'b0; pend_rd = 1'b0; pend_wr = 1'b0;
    host_wdata = '0; host_be = '0; mem_dq_i = '0;
    repeat (3) @(posedge clk);
    #1;
    #8;
    chk("R1 reset dq_t", mem_dq_t, 1);
    chk("R1 reset dq_o", mem_dq_o, 0);
    chk("R1 reset dqm", mem_dqm, 0);
    chk("R1 reset rvalid", host_rvalid, 0);
    chk("R1 reset done", xfer_done, 0);
    chk("R1 reset wnext", host_wnext, 0);
    step();
    rst = 1'b0;
    step();

    // R9: strobe without any pending flag is ignored
    data_en = 1'b1;
    step();
    data_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #8;
      chk("R9 ignored strobe dq_t", mem_dq_t, 1);
      chk("R9 ignored strobe done", xfer_done, 0);
      chk("R9 ignored strobe rvalid", host_rvalid, 0);
      step();
    end

    // R2 R3 R4: single, triple and double word reads
    read_burst(1, 64'h0123_4567_89AB_CDEF, '0, '0);
    read_burst(3, 64'hFEDC_BA98_7654_3210, 64'h8000_0000_0000_0001, 64'h1111_2222_3333_4444);
    // R9: both flags set selects a read
    pend_wr = 1'b1;
    read_burst(2, 64'hA5A5_5A5A_0F0F_F0F0, 64'hDEAD_BEEF_CAFE_F00D, '0);
    pend_wr = 1'b0;

    // R5 R6 R8: single-byte enable sweep over all lanes
    for (int k = 0; k < NB; k++) begin
      write_burst(1, 64'h0102_0304_0506_0708 * 64'(k + 1), '0, '0,
                  NB'(1) << k, '0, '0);
    end
    write_burst(2, 64'hCAFE_BABE_1234_5678, 64'h9ABC_DEF0_0FED_CBA9, '0,
                8'hFF, 8'h3C, '0);
    write_burst(3, 64'h0000_FFFF_0000_FFFF, 64'h5555_AAAA_5555_AAAA, 64'h7777_8888_9999_0000,
                8'h00, 8'hA5, 8'hFF);

    // R9: read straight after writes still starts cleanly
    read_burst(1, 64'h2468_ACE0_1357_9BDF, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule